// File: doc/BRIEF.md
# Programmable YUV to RGB Colour Converter

This block turns a stream of 8-bit luma and chroma samples into 8-bit red, green and blue samples. A programmable 3x4 fixed-point matrix does the conversion. Each output channel has its own row, with three multipliers for Y, U and V and one offset constant. After reset the matrix holds a limited-range BT.601 to full-range RGB conversion. Software can overwrite any of the twelve matrix words through a simple write port.

Pixels enter and leave on valid/ready handshakes. Each pixel carries a bypass flag. A flagged pixel is taken to be RGB already, and its three lanes come out unchanged. Flagged and unflagged pixels share the same fixed two-cycle latency and the same flow control, so the two kinds can be mixed freely in one stream.

Top module: `csc_matrix`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0, in_ready is 1, and all twelve matrix words hold their default values.
- R2: Matrix word address a (0 to 11) selects row a/4 and column a%4. Rows 0, 1 and 2 produce G, R and B. Columns 0, 1 and 2 weight Y (lane 0), U (lane 1) and V (lane 2), and column 3 is the row constant. A write with cfg_we high takes effect for pixels accepted from the next clock edge onward.
- R3: The multiplier words (columns 0 to 2) use the low 13 bits of cfg_wdata as a signed value with 10 fractional bits, and bit 13 is ignored. A constant word (column 3) uses all 14 bits as a signed value with 4 fractional bits.
- R4: Each row computes acc = cY*Y + cU*U + cV*V + k*64. The result is floor((acc + 512) / 1024).
- R5: Each matrix result is clamped to the range 0 to 255.
- R6: The default words in hex are: G row 04A7, 1E6F, 1CBF, 0877; R row 04A7, 0000, 0662, 3211; B row 04A7, 0812, 0000, 2EB1.
- R7: When in_byp is high on an accepted pixel, out_r equals lane 0, out_g equals lane 1 and out_b equals lane 2, unchanged.
- R8: A pixel accepted at clock edge k appears with out_valid high after edge k+1. This holds in both modes.
- R9: While out_valid is high and out_ready is low, the outputs hold steady and in_ready is low. Otherwise in_ready is high.
- R10: Writes to addresses 12 to 15 change no matrix word.
- R11: Back-to-back pixels are accepted one per cycle and leave in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Matrix word write strobe |
| cfg_addr | input | 4 | Matrix word address |
| cfg_wdata | input | 14 | Matrix word write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_byp | input | 1 | Pixel is RGB; pass lanes through |
| in_c0 | input | 8 | Lane 0: Y, or R in bypass |
| in_c1 | input | 8 | Lane 1: U, or G in bypass |
| in_c2 | input | 8 | Lane 2: V, or B in bypass |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts output pixel |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
The bench builds the block with its default parameters: 8-bit samples, 14-bit coefficient words, 10 fractional bits in the multipliers and 4 in the constant. With these values the default hex table is bit-exact, which lets the bench reach both clamp limits with ordinary sample values. It also lets the bench set up exact rounding ties at one half using small constants, and check that bit 13 is dropped from the 13-bit multiplier fields.

// File: rtl/csc_pkg.sv
// Shared constants and the reset-time matrix for the colour converter.
// Assumes 14-bit coefficient words; multiplier words are stored sign-extended.
package csc_pkg;
    localparam int ROWS   = 3;
    localparam int COLS   = 4;
    localparam int NWORD  = ROWS * COLS;
    localparam int ADDR_W = 4;

    // Reset-time word for a given address (BT.601 limited to full range).
    function automatic logic [13:0] dflt_word(input int idx);
        case (idx)
            0:  return 14'h04A7;
            1:  return 14'h1E6F;
            2:  return 14'h1CBF;
            3:  return 14'h0877;
            4:  return 14'h04A7;
            5:  return 14'h0000;
            6:  return 14'h0662;
            7:  return 14'h3211;
            8:  return 14'h04A7;
            9:  return 14'h0812;
            10: return 14'h0000;
            11: return 14'h2EB1;
            default: return 14'h0000;
        endcase
    endfunction
endpackage

// File: rtl/csc_coef_bank.sv
// Twelve-word matrix store with a single write port.
// Multiplier slots keep the sign-extended low CW bits of the write data;
// constant slots (address bits [1:0] == 3) keep all KW bits.
// Out-of-range addresses are dropped.
module csc_coef_bank import csc_pkg::*; #(
    parameter int CW = 13,
    parameter int KW = 14
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [KW-1:0]               cfg_wdata,
    output logic [NWORD-1:0][KW-1:0]    words
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NWORD - 1);

    // Bring a raw word to the stored form for its column.
    function automatic logic [KW-1:0] fit(input logic is_const, input logic [KW-1:0] d);
        logic signed [CW-1:0] m;
        m = $signed(d[CW-1:0]);
        return is_const ? d : KW'(m);
    endfunction

    // Load defaults on reset; accept in-range writes afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORD; i++)
                words[i] <= fit(i % COLS == COLS - 1, KW'(dflt_word(i)));
        end else if (cfg_we && cfg_addr <= LAST) begin
            words[cfg_addr] <= fit(cfg_addr[1:0] == 2'b11, cfg_wdata);
        end
    end

    // R10: writes beyond the last word leave every word untouched.
    a_r10_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_addr > LAST |=> $stable(words));

    // R2: a constant-slot write lands exactly where addressed.
    a_r2_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_addr <= LAST && cfg_addr[1:0] == 2'b11
        |=> words[$past(cfg_addr)] == $past(cfg_wdata));
endmodule

// File: rtl/csc_row.sv
// One output channel: three products plus a scaled constant, then
// round-half-up at the FRAC binary point and clamp to the sample range.
// Two register stages, both advancing only on adv. Assumes coefficient
// words arrive already sign-extended to KW bits.
module csc_row #(
    parameter int DW    = 8,
    parameter int KW    = 14,
    parameter int FRAC  = 10,
    parameter int KFRAC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic [DW-1:0]        smp_y,
    input  logic [DW-1:0]        smp_u,
    input  logic [DW-1:0]        smp_v,
    input  logic [DW-1:0]        pass_in,
    input  logic                 byp_in,
    input  logic [3:0][KW-1:0]   coef,
    output logic [DW-1:0]        res
);
    localparam int PW = KW + DW + 1;
    localparam int AW = PW + 3;
    localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC - 1);
    localparam logic signed [AW-1:0] MAXV = AW'((1 << DW) - 1);

    logic signed [KW-1:0] cy, cu, cv, ck;
    logic signed [PW-1:0] py, pu, pv;
    logic signed [AW-1:0] acc_n, acc_q, rnd;
    logic [DW-1:0]        pass_q, sat;
    logic                 byp_q;

    // Multiply-accumulate for the pixel being accepted.
    always_comb begin
        cy = $signed(coef[0]);
        cu = $signed(coef[1]);
        cv = $signed(coef[2]);
        ck = $signed(coef[3]);
        py = PW'(cy) * PW'($signed({1'b0, smp_y}));
        pu = PW'(cu) * PW'($signed({1'b0, smp_u}));
        pv = PW'(cv) * PW'($signed({1'b0, smp_v}));
        acc_n = AW'(py) + AW'(pu) + AW'(pv) + (AW'(ck) <<< (FRAC - KFRAC));
    end

    // Stage A: hold the sum, the bypass flag and the pass-through lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            byp_q  <= 1'b0;
            pass_q <= '0;
        end else if (adv) begin
            acc_q  <= acc_n;
            byp_q  <= byp_in;
            pass_q <= pass_in;
        end
    end

    // Round to integer and saturate into the sample range.
    always_comb begin
        rnd = (acc_q + HALF) >>> FRAC;
        if (rnd[AW-1])
            sat = '0;
        else if (rnd > MAXV)
            sat = '1;
        else
            sat = rnd[DW-1:0];
    end

    // Stage B: select the matrix result or the untouched lane.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res <= '0;
        else if (adv)
            res <= byp_q ? pass_q : sat;
    end

    // R7: a bypassed pixel leaves exactly as it entered stage A.
    a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        byp_q && adv |=> res == $past(pass_q));
endmodule

// File: rtl/csc_flow.sv
// Valid tracking for the two-stage lockstep pipeline. The whole pipe
// advances when the output slot is empty or being drained.
module csc_flow (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic adv,
    output logic out_valid
);
    logic v_a;

    // Advance condition shared by every stage.
    always_comb begin
        adv      = !out_valid || out_ready;
        in_ready = adv;
    end

    // Move valid bits one stage per advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_a       <= 1'b0;
            out_valid <= 1'b0;
        end else if (adv) begin
            v_a       <= in_valid;
            out_valid <= v_a;
        end
    end

    // R8: a pixel in stage A reaches the output on the next advance.
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        v_a && adv |=> out_valid);
endmodule

// File: rtl/csc_matrix.sv
// YUV to RGB converter top. Lanes 0..2 carry Y,U,V (or R,G,B when the
// pixel's bypass flag is set). Row 0 drives G, row 1 drives R, row 2 drives B.
// Latency is two accepted cycles in both modes.
module csc_matrix import csc_pkg::*; #(
    parameter int DW    = 8,
    parameter int CW    = 13,
    parameter int KW    = 14,
    parameter int FRAC  = 10,
    parameter int KFRAC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [KW-1:0]     cfg_wdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_byp,
    input  logic [DW-1:0]     in_c0,
    input  logic [DW-1:0]     in_c1,
    input  logic [DW-1:0]     in_c2,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DW-1:0]     out_r,
    output logic [DW-1:0]     out_g,
    output logic [DW-1:0]     out_b
);
    logic [NWORD-1:0][KW-1:0] words;
    logic [2:0][DW-1:0]       lane;
    logic [ROWS-1:0][DW-1:0]  row_res;
    logic                     adv;

    assign lane = {in_c2, in_c1, in_c0};

    csc_coef_bank #(.CW(CW), .KW(KW)) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .words(words)
    );

    csc_flow u_flow (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
        .in_ready(in_ready), .adv(adv), .out_valid(out_valid)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        // Bypass lane that feeds this row's colour: G<-1, R<-0, B<-2.
        localparam int PASS = (r == 0) ? 1 : ((r == 1) ? 0 : 2);
        csc_row #(.DW(DW), .KW(KW), .FRAC(FRAC), .KFRAC(KFRAC)) u_row (
            .clk(clk), .rst_n(rst_n), .adv(adv),
            .smp_y(lane[0]), .smp_u(lane[1]), .smp_v(lane[2]),
            .pass_in(lane[PASS]), .byp_in(in_byp),
            .coef(words[COLS*r+COLS-1 : COLS*r]),
            .res(row_res[r])
        );
    end

    assign out_g = row_res[0];
    assign out_r = row_res[1];
    assign out_b = row_res[2];

    // R9: a stalled output pixel stays put.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_r)
                                    && $stable(out_g) && $stable(out_b));
endmodule

// File: tb/sim_csc_matrix.sv
module sim_csc_matrix;
    logic clk = 1'b0;
    logic rst_n, cfg_we, in_valid, in_ready, in_byp, out_valid, out_ready;
    logic [3:0]  cfg_addr;
    logic [13:0] cfg_wdata;
    logic [7:0]  in_c0, in_c1, in_c2, out_r, out_g, out_b;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;
    int bc[12];

    always #2ns clk = ~clk;

    csc_matrix u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_byp(in_byp), .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    function automatic int sx(int v, int w);
        return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
    endfunction

    // Reference row per R2..R5 from the bench's own word copy.
    function automatic int mrow(int r, int a, int b, int c);
        int acc, res;
        acc = sx(bc[4*r] & 8191, 13) * a + sx(bc[4*r+1] & 8191, 13) * b
            + sx(bc[4*r+2] & 8191, 13) * c + sx(bc[4*r+3] & 16383, 14) * 64;
        res = (acc + 512) >>> 10;
        if (res < 0) res = 0;
        if (res > 255) res = 255;
        return res;
    endfunction

    task automatic chk(string rq, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic set_defaults();
        bc = '{'h04A7, 'h1E6F, 'h1CBF, 'h0877, 'h04A7, 'h0000,
               'h0662, 'h3211, 'h04A7, 'h0812, 'h0000, 'h2EB1};
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 14'(d);
        if (a < 12) bc[a] = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic expect_px(string rq, bit byp, int a, int b, int c);
        if (byp) begin
            chk({rq, " r"}, out_r, a); chk({rq, " g"}, out_g, b); chk({rq, " b"}, out_b, c);
        end else begin
            chk({rq, " r"}, out_r, mrow(1, a, b, c));
            chk({rq, " g"}, out_g, mrow(0, a, b, c));
            chk({rq, " b"}, out_b, mrow(2, a, b, c));
        end
    endtask

    // One pixel through an idle pipe; checks R8 latency and the values.
    task automatic px(string rq, bit byp, int a, int b, int c);
        @(negedge clk);
        in_valid = 1; in_byp = byp; in_c0 = 8'(a); in_c1 = 8'(b); in_c2 = 8'(c);
        @(negedge clk);
        in_valid = 0;
        chk("R8 not yet valid", out_valid, 0);
        @(negedge clk);
        chk("R8 valid after two edges", out_valid, 1);
        expect_px(rq, byp, a, b, c);
    endtask

    task automatic t_reset();
        rst_n = 0; cfg_we = 0; in_valid = 0; in_byp = 0; out_ready = 1;
        cfg_addr = 0; cfg_wdata = 0; in_c0 = 0; in_c1 = 0; in_c2 = 0;
        set_defaults();
        repeat (3) @(negedge clk);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 in_ready", in_ready, 1);
        rst_n = 1;
    endtask

    task automatic t_default();
        px("R6 black", 0, 16, 128, 128);
        chk("R6 black r", out_r, 0);
        px("R6 white", 0, 235, 128, 128);
        chk("R6 white g", out_g, 255);
        px("R6 red", 0, 81, 90, 240);
        px("R6 green", 0, 145, 54, 34);
        px("R4 mid", 0, 100, 200, 50);
    endtask

    task automatic t_clamp();
        px("R5 low", 0, 0, 0, 0);
        chk("R5 low r", out_r, 0);
        px("R5 high", 0, 255, 255, 255);
        chk("R5 high b", out_b, 255);
        px("R5 mixed", 0, 16, 240, 16);
    endtask

    task automatic t_bypass();
        px("R7 pass", 1, 200, 3, 77);
        px("R7 pass edges", 1, 0, 255, 128);
    endtask

    task automatic t_program();
        for (int i = 0; i < 12; i++) wr(i, 0);
        wr(1, 1024);            // G <- U
        wr(6, 'h2000 | 1024);   // R <- V, bit 13 ignored (R3)
        wr(8, 1024);            // B <- Y
        px("R2 routing", 0, 10, 20, 30);
        chk("R2 g is U", out_g, 20);
        chk("R3 r is V", out_r, 30);
        chk("R2 b is Y", out_b, 10);
        wr(7, 8);               // R constant +0.5 on V
        px("R4 tie up", 0, 10, 20, 30);
        chk("R4 tie up r", out_r, 31);
        wr(7, 7);
        px("R4 below tie", 0, 10, 20, 30);
        chk("R4 below tie r", out_r, 30);
        wr(11, 'h3FF8);         // B constant -0.5
        px("R4 negative tie", 0, 10, 20, 30);
        chk("R4 negative tie b", out_b, 10);
        wr(11, 'h3FF7);         // B constant -0.5625
        px("R4 below negative tie", 0, 10, 20, 30);
        chk("R4 below negative tie b", out_b, 9);
    endtask

    task automatic t_bad_addr();
        for (int a = 12; a < 16; a++) wr(a, 'h1555);
        px("R10 words intact", 0, 40, 50, 60);
    endtask

    task automatic t_stall();
        @(negedge clk);
        out_ready = 0;
        in_valid = 1; in_byp = 0; in_c0 = 8'd90; in_c1 = 8'd60; in_c2 = 8'd30;
        @(negedge clk);
        in_valid = 0;
        chk("R9 ready while slot empty", in_ready, 1);
        @(negedge clk);
        chk("R9 valid", out_valid, 1);
        chk("R9 ready low when stalled", in_ready, 0);
        in_valid = 1; in_byp = 1; in_c0 = 8'd1; in_c1 = 8'd2; in_c2 = 8'd3;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9 held valid", out_valid, 1);
            expect_px("R9 held", 0, 90, 60, 30);
        end
        out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        chk("R9 drained", out_valid, 0);
        @(negedge clk);
        chk("R9 second valid", out_valid, 1);
        expect_px("R9 second", 1, 1, 2, 3);
        @(negedge clk);
        chk("R9 delivered once", out_valid, 0);
    endtask

    task automatic t_stream();
        @(negedge clk);
        in_valid = 1; in_byp = 0; in_c0 = 8'd120; in_c1 = 8'd100; in_c2 = 8'd160;
        @(negedge clk);
        chk("R11 accept 2", in_ready, 1);
        in_byp = 1; in_c0 = 8'd11; in_c1 = 8'd22; in_c2 = 8'd33;
        @(negedge clk);
        chk("R11 accept 3", in_ready, 1);
        in_byp = 0; in_c0 = 8'd60; in_c1 = 8'd200; in_c2 = 8'd90;
        chk("R11 first valid", out_valid, 1);
        expect_px("R11 first", 0, 120, 100, 160);
        @(negedge clk);
        in_valid = 0;
        chk("R11 second valid", out_valid, 1);
        expect_px("R11 second", 1, 11, 22, 33);
        @(negedge clk);
        chk("R11 third valid", out_valid, 1);
        expect_px("R11 third", 0, 60, 200, 90);
        @(negedge clk);
        chk("R11 stream end", out_valid, 0);
    endtask

    task automatic t_reset_restores();
        wr(0, 0);
        @(negedge clk);
        rst_n = 0;
        set_defaults();
        @(negedge clk);
        rst_n = 1;
        px("R1 defaults back", 0, 180, 70, 200);
    endtask

    initial begin
        t_reset();
        t_default();
        t_clamp();
        t_bypass();
        t_stall();
        t_stream();
        t_bad_addr();
        t_program();
        t_bad_addr();
        t_reset_restores();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R8 watchdog: got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule